// File: doc/BRIEF.md
# Table-Driven Serial Flash Sequencer

This block runs serial-memory transactions from a small program held in an on-chip instruction table rather than from fixed logic. A host fills the table, then starts a transaction by pulsing a trigger that carries a sequence index, a start address and a data byte count. The engine fetches 16-bit instructions one at a time from that sequence. Each instruction produces one phase on the wire: an opcode byte, a slice of the address, idle (dummy) clocks, data taken from a transmit FIFO, or data placed into a receive FIFO. A stop instruction ends the transaction.

Every phase picks its own bus width of 1, 2, 4 or 8 data lines. The serial clock runs at half the system clock: each bus beat spends one cycle with the clock low, while the data lines are set up, and one cycle with it high. When the data path cannot proceed, the engine holds the clock low and chip select asserted, and waits. A one-cycle completion pulse marks a sequence that ends cleanly. A one-cycle error pulse marks a sequence that was aborted.

Top module: `flash_seq_engine`

## Requirements
- R1: After reset, idle_o is 1, cs_no is 1, sck_o is 0, and done_o and err_o are 0.
- R2: An instruction is 16 bits: opcode in bits [15:10], pad code in [9:8] and operand in [7:0]. Table word w holds instruction 2w in bits [15:0] and instruction 2w+1 in bits [31:16]. Sequence s occupies words 4s to 4s+3. A word written at tbl_addr_i reads back on tbl_rdata_o at the same address.
- R3: Opcode 0x01 (command) shifts out its 8-bit operand, MSB first.
- R4: Pad codes 0, 1, 2 and 3 select 1, 2, 4 and 8 lines. A beat places the next N most significant bits on dq_o[N-1:0], with the earlier bit on the higher line. Only those lines are enabled in dq_oe_o. Each beat is one clock low followed by one clock high on sck_o.
- R5: Opcode 0x02 (address) shifts out the low K bits of the trigger address, MSB first, where K is the operand and lies in the range 1 to 32. Shifting takes ceil(K/N) beats.
- R6: Opcode 0x0C (dummy) produces K beats with no line enabled, where K is the operand and lies in the range 1 to 64.
- R7: Opcode 0x08 (write) pops the trigger byte count of bytes from the transmit FIFO. Each byte is sent over 8/N beats. While the FIFO is empty before a byte, sck_o stays low and cs_no stays low. A count of zero skips the phase.
- R8: Opcode 0x09 (read) assembles the trigger byte count of bytes from dq_i and pushes each finished byte. While rx_full_i is high, the push waits and no further beat is issued.
- R9: Opcode 0x00 (stop) deasserts cs_no, gives a single-cycle done_o and returns to idle.
- R10: The sequence aborts when it meets any of the following: an undefined opcode, an address operand outside 1 to 32, a dummy operand outside 1 to 64, or a ninth instruction fetch. An abort gives a single-cycle err_o and no done_o, and it deasserts cs_no and returns to idle.
- R11: A trigger is accepted only while idle_o is 1. A trigger given at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table word write enable |
| tbl_addr_i | input | TBL_AW | Table word address for write and readback |
| tbl_wdata_i | input | 32 | Table write data |
| tbl_rdata_o | output | 32 | Table readback data |
| trig_i | input | 1 | Start request |
| trig_seq_i | input | SEQ_AW | Sequence index |
| trig_addr_i | input | 32 | Transaction start address |
| trig_len_i | input | LEN_W | Data byte count |
| idle_o | output | 1 | Engine is idle and will accept a trigger |
| done_o | output | 1 | One-cycle pulse when a sequence ends on a stop instruction |
| err_o | output | 1 | One-cycle pulse when a sequence aborts |
| tx_data_i | input | 8 | Head byte of the transmit FIFO |
| tx_empty_i | input | 1 | Transmit FIFO is empty |
| tx_pop_o | output | 1 | Pop the transmit FIFO head |
| rx_data_o | output | 8 | Byte to push into the receive FIFO |
| rx_full_i | input | 1 | Receive FIFO is full |
| rx_push_o | output | 1 | Push rx_data_o |
| cs_no | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| dq_o | output | 8 | Data line outputs |
| dq_oe_o | output | 8 | Per-line output enables |
| dq_i | input | 8 | Data line inputs |

## Verification
A wrong program counter or a wrong half-word select shows up within one beat. It appears as a wrong opcode on the lines, a missing stop, or an early err_o. A beat counter that is off by one changes the number of sck_o rising edges in a phase, so the bench counts beats exactly for each phase. A wrong read shift or lane mask corrupts the first pushed byte, about 8/N beats into the read phase. A stall that is not handled shows up as sck_o edges, or as a pop or push, while the bench holds a FIFO empty or full.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [5:0] {
    OP_STOP  = 6'h00,
    OP_CMD   = 6'h01,
    OP_ADDR  = 6'h02,
    OP_WRITE = 6'h08,
    OP_READ  = 6'h09,
    OP_DUMMY = 6'h0C
  } fs_op_e;

  typedef struct packed {
    logic [5:0] op;
    logic [1:0] pad;
    logic [7:0] arg;
  } fs_instr_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEC, ST_LOW, ST_HIGH, ST_TXW, ST_RXW
  } fs_state_e;

  localparam int unsigned WORDS_PER_SEQ = 4;
  localparam int unsigned MAX_ADDR_BITS = 32;
  localparam int unsigned MAX_DUMMY     = 64;

  function automatic logic [6:0] fs_byte_beats(logic [1:0] pad);
    return 7'd8 >> pad;
  endfunction
endpackage

// File: rtl/fseq_table.sv
module fseq_table import flash_seq_pkg::*; #(
  parameter int unsigned NSEQ = 16,
  localparam int unsigned SEQ_AW = $clog2(NSEQ),
  localparam int unsigned TBL_AW = SEQ_AW + 2,
  localparam int unsigned DEPTH  = NSEQ * WORDS_PER_SEQ
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [TBL_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [SEQ_AW-1:0] fseq_i,
  input  logic [2:0]        fpc_i,
  output fs_instr_t         instr_o
);
  logic [31:0] mem_q [DEPTH];
  logic [31:0] fword;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
  assign fword   = mem_q[{fseq_i, fpc_i[2:1]}];
  // even index in low half, odd index in high half
  assign instr_o = fpc_i[0] ? fs_instr_t'(fword[31:16]) : fs_instr_t'(fword[15:0]);
endmodule

// File: rtl/fseq_lanes.sv
module fseq_lanes (
  input  logic [1:0] pad_i,
  input  logic       drive_i,
  input  logic [7:0] tx_top_i,
  input  logic [7:0] rx_acc_i,
  input  logic [7:0] dq_i,
  output logic [7:0] dq_o,
  output logic [7:0] dq_oe_o,
  output logic [7:0] rx_next_o
);
  logic [3:0] n_lanes;
  logic [7:0] mask, grp;

  assign n_lanes = 4'd1 << pad_i;
  assign mask    = 8'hFF >> (4'd8 - n_lanes);
  assign grp     = tx_top_i >> (4'd8 - n_lanes);

  for (genvar l = 0; l < 8; l++) begin : g_lane
    assign dq_oe_o[l] = drive_i & mask[l];
    assign dq_o[l]    = drive_i & mask[l] & grp[l];
  end

  assign rx_next_o = (rx_acc_i << n_lanes) | (dq_i & mask);
endmodule

// File: rtl/flash_seq_engine.sv
module flash_seq_engine import flash_seq_pkg::*; #(
  parameter int unsigned NSEQ  = 16,
  parameter int unsigned LEN_W = 12,
  localparam int unsigned SEQ_AW = $clog2(NSEQ),
  localparam int unsigned TBL_AW = SEQ_AW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_we_i,
  input  logic [TBL_AW-1:0] tbl_addr_i,
  input  logic [31:0]       tbl_wdata_i,
  output logic [31:0]       tbl_rdata_o,
  input  logic              trig_i,
  input  logic [SEQ_AW-1:0] trig_seq_i,
  input  logic [31:0]       trig_addr_i,
  input  logic [LEN_W-1:0]  trig_len_i,
  output logic              idle_o,
  output logic              done_o,
  output logic              err_o,
  input  logic [7:0]        tx_data_i,
  input  logic              tx_empty_i,
  output logic              tx_pop_o,
  output logic [7:0]        rx_data_o,
  input  logic              rx_full_i,
  output logic              rx_push_o,
  output logic              cs_no,
  output logic              sck_o,
  output logic [7:0]        dq_o,
  output logic [7:0]        dq_oe_o,
  input  logic [7:0]        dq_i
);
  fs_state_e         st_q;
  logic [3:0]        pc_q;
  logic [SEQ_AW-1:0] seq_q;
  logic [31:0]       addr_q, sr_q;
  logic [LEN_W-1:0]  len_q, bytes_q;
  logic [5:0]        op_q;
  logic [1:0]        pad_q;
  logic [6:0]        beats_q;
  logic [7:0]        rx_q, rx_next;
  logic              cs_q, done_q, err_q;

  fs_instr_t  ins;
  logic       dec_bad;
  logic [3:0] dec_n, lane_n;
  logic [8:0] addr_sum;
  logic [6:0] addr_beats;
  logic       drive;

  fseq_table #(.NSEQ(NSEQ)) u_table (
    .clk_i   (clk_i),
    .we_i    (tbl_we_i),
    .addr_i  (tbl_addr_i),
    .wdata_i (tbl_wdata_i),
    .rdata_o (tbl_rdata_o),
    .fseq_i  (seq_q),
    .fpc_i   (pc_q[2:0]),
    .instr_o (ins)
  );

  always_comb begin
    dec_n      = 4'd1 << ins.pad;
    addr_sum   = {1'b0, ins.arg} + {5'd0, dec_n} - 9'd1;
    addr_beats = 7'(addr_sum >> ins.pad);
    case (ins.op)
      OP_STOP, OP_CMD, OP_WRITE, OP_READ: dec_bad = 1'b0;
      OP_ADDR:  dec_bad = (ins.arg == 8'd0) || (ins.arg > 8'(MAX_ADDR_BITS));
      OP_DUMMY: dec_bad = (ins.arg == 8'd0) || (ins.arg > 8'(MAX_DUMMY));
      default:  dec_bad = 1'b1;
    endcase
  end

  assign lane_n = 4'd1 << pad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      pc_q    <= '0;
      seq_q   <= '0;
      addr_q  <= '0;
      sr_q    <= '0;
      len_q   <= '0;
      bytes_q <= '0;
      op_q    <= '0;
      pad_q   <= '0;
      beats_q <= '0;
      rx_q    <= '0;
      cs_q    <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        ST_IDLE: if (trig_i) begin
          seq_q  <= trig_seq_i;
          addr_q <= trig_addr_i;
          len_q  <= trig_len_i;
          pc_q   <= '0;
          cs_q   <= 1'b0;
          st_q   <= ST_DEC;
        end
        ST_DEC: begin
          op_q  <= ins.op;
          pad_q <= ins.pad;
          if (pc_q[3] || dec_bad) begin
            err_q <= 1'b1;
            cs_q  <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            case (ins.op)
              OP_STOP: begin
                done_q <= 1'b1;
                cs_q   <= 1'b1;
                st_q   <= ST_IDLE;
              end
              OP_CMD: begin
                sr_q    <= {ins.arg, 24'h0};
                beats_q <= fs_byte_beats(ins.pad);
                st_q    <= ST_LOW;
              end
              OP_ADDR: begin
                sr_q    <= addr_q << (6'd32 - ins.arg[5:0]);
                beats_q <= addr_beats;
                st_q    <= ST_LOW;
              end
              OP_DUMMY: begin
                sr_q    <= '0;
                beats_q <= ins.arg[6:0];
                st_q    <= ST_LOW;
              end
              OP_WRITE, OP_READ: begin
                if (len_q == '0) begin
                  pc_q <= pc_q + 4'd1;
                end else begin
                  bytes_q <= len_q;
                  beats_q <= fs_byte_beats(ins.pad);
                  rx_q    <= '0;
                  st_q    <= (ins.op == OP_WRITE) ? ST_TXW : ST_LOW;
                end
              end
              default: st_q <= ST_IDLE;
            endcase
          end
        end
        ST_TXW: if (!tx_empty_i) begin
          sr_q    <= {tx_data_i, 24'h0};
          beats_q <= fs_byte_beats(pad_q);
          st_q    <= ST_LOW;
        end
        ST_LOW: st_q <= ST_HIGH;
        ST_HIGH: begin
          sr_q <= sr_q << lane_n;
          if (op_q == OP_READ) rx_q <= rx_next;
          if (beats_q == 7'd1) begin
            case (op_q)
              OP_WRITE: begin
                if (bytes_q == LEN_W'(1)) begin
                  pc_q <= pc_q + 4'd1;
                  st_q <= ST_DEC;
                end else begin
                  bytes_q <= bytes_q - LEN_W'(1);
                  st_q    <= ST_TXW;
                end
              end
              OP_READ: st_q <= ST_RXW;
              default: begin
                pc_q <= pc_q + 4'd1;
                st_q <= ST_DEC;
              end
            endcase
          end else begin
            beats_q <= beats_q - 7'd1;
            st_q    <= ST_LOW;
          end
        end
        ST_RXW: if (!rx_full_i) begin
          if (bytes_q == LEN_W'(1)) begin
            pc_q <= pc_q + 4'd1;
            st_q <= ST_DEC;
          end else begin
            bytes_q <= bytes_q - LEN_W'(1);
            beats_q <= fs_byte_beats(pad_q);
            rx_q    <= '0;
            st_q    <= ST_LOW;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign drive = ((st_q == ST_LOW) || (st_q == ST_HIGH)) &&
                 ((op_q == OP_CMD) || (op_q == OP_ADDR) || (op_q == OP_WRITE));

  fseq_lanes u_lanes (
    .pad_i     (pad_q),
    .drive_i   (drive),
    .tx_top_i  (sr_q[31:24]),
    .rx_acc_i  (rx_q),
    .dq_i      (dq_i),
    .dq_o      (dq_o),
    .dq_oe_o   (dq_oe_o),
    .rx_next_o (rx_next)
  );

  assign idle_o    = (st_q == ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign cs_no     = cs_q;
  assign sck_o     = (st_q == ST_HIGH);
  assign tx_pop_o  = (st_q == ST_TXW) && !tx_empty_i;
  assign rx_push_o = (st_q == ST_RXW) && !rx_full_i;
  assign rx_data_o = rx_q;
endmodule

// File: rtl/flash_seq_engine_chk.sv
module flash_seq_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       idle_o,
  input logic       done_o,
  input logic       err_o,
  input logic       cs_no,
  input logic       sck_o,
  input logic       tx_pop_o,
  input logic       tx_empty_i,
  input logic       rx_push_o,
  input logic       rx_full_i,
  input logic [7:0] dq_oe_o
);
  AST_IDLE_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> cs_no);                                                  // R1
  AST_SCK_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_no);                                                  // R4
  AST_OE_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o == 8'h00) || (dq_oe_o == 8'h01) || (dq_oe_o == 8'h03) ||
    (dq_oe_o == 8'h0F) || (dq_oe_o == 8'hFF));                          // R4
  AST_SCK_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |=> !sck_o);                                                  // R4
  AST_NO_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> !tx_empty_i);                                          // R7
  AST_NO_PUSH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> !rx_full_i);                                          // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                                // R9
  AST_DONE_AT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (idle_o && cs_no));                                      // R9
  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!done_o && idle_o));                                     // R10
endmodule

bind flash_seq_engine flash_seq_engine_chk chk_i (.*);

// File: tb/flash_seq_engine_tb_top.sv
module flash_seq_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TBL_AW = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tbl_we_i = 1'b0;
  logic [TBL_AW-1:0] tbl_addr_i = '0;
  logic [31:0] tbl_wdata_i = '0, tbl_rdata_o;
  logic trig_i = 1'b0;
  logic [3:0] trig_seq_i = '0;
  logic [31:0] trig_addr_i = '0;
  logic [11:0] trig_len_i = '0;
  logic idle_o, done_o, err_o, tx_pop_o, rx_push_o, cs_no, sck_o;
  logic [7:0] tx_data_i, rx_data_o, dq_o, dq_oe_o;
  logic [7:0] dq_i = 8'h00;
  logic tx_empty_i, rx_full_i;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_seq_engine dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i), .tbl_wdata_i(tbl_wdata_i),
    .tbl_rdata_o(tbl_rdata_o),
    .trig_i(trig_i), .trig_seq_i(trig_seq_i), .trig_addr_i(trig_addr_i),
    .trig_len_i(trig_len_i),
    .idle_o(idle_o), .done_o(done_o), .err_o(err_o),
    .tx_data_i(tx_data_i), .tx_empty_i(tx_empty_i), .tx_pop_o(tx_pop_o),
    .rx_data_o(rx_data_o), .rx_full_i(rx_full_i), .rx_push_o(rx_push_o),
    .cs_no(cs_no), .sck_o(sck_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .dq_i(dq_i)
  );

  int checks = 0, fails = 0;

  // transmit FIFO model
  logic [7:0] tx_mem [16];
  int tx_rd = 0, tx_wr = 0;
  logic tx_block = 1'b0;
  assign tx_empty_i = (tx_rd == tx_wr) || tx_block;
  assign tx_data_i  = tx_mem[tx_rd % 16];

  // receive FIFO model
  logic [7:0] rx_got [16];
  int rx_n = 0;
  logic rx_block = 1'b0;
  assign rx_full_i = rx_block;

  always @(posedge clk) begin
    if (tx_pop_o) tx_rd <= tx_rd + 1;
    if (rx_push_o) begin
      rx_got[rx_n % 16] <= rx_data_o;
      rx_n <= rx_n + 1;
    end
  end

  // wire monitor and read-data responder
  logic [7:0] beat_dq [512];
  logic [7:0] beat_oe [512];
  int nb = 0, z_cnt = 0, done_cnt = 0, err_cnt = 0;
  logic sck_prev = 1'b0;
  logic [7:0] rd_bytes [4];
  int rd_n = 1, rd_skip = 0, rd_z0 = 0;
  logic rd_en = 1'b0;

  function automatic logic [7:0] rd_group(int gi);
    logic [7:0] g = 8'h00;
    for (int k = 0; k < rd_n; k++) begin
      int p = gi * rd_n + k;
      g = {g[6:0], rd_bytes[(p / 8) % 4][7 - (p % 8)]};
    end
    return g;
  endfunction

  always @(negedge clk) begin
    int gi;
    sck_prev <= sck_o;
    if (sck_o && !sck_prev) begin
      beat_dq[nb % 512] <= dq_o;
      beat_oe[nb % 512] <= dq_oe_o;
      nb <= nb + 1;
      if (dq_oe_o == 8'h00) begin
        gi = z_cnt - rd_z0 - rd_skip;
        dq_i <= (rd_en && gi >= 0) ? rd_group(gi) : 8'h00;
        z_cnt <= z_cnt + 1;
      end
    end
    if (done_o) done_cnt <= done_cnt + 1;
    if (err_o)  err_cnt  <= err_cnt + 1;
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(logic [5:0] op, logic [1:0] pad, logic [7:0] arg);
    return {op, pad, arg};
  endfunction

  task automatic write_word(logic [TBL_AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    tbl_we_i = 1'b1; tbl_addr_i = a; tbl_wdata_i = d;
    @(negedge clk);
    tbl_we_i = 1'b0;
  endtask

  task automatic load(logic [3:0] seq, logic [7:0][15:0] p);
    for (int k = 0; k < 4; k++)
      write_word({seq, 2'(k)}, {p[2*k+1], p[2*k]});
  endtask

  task automatic fire(logic [3:0] seq, logic [31:0] addr, logic [11:0] len);
    @(negedge clk);
    trig_i = 1'b1; trig_seq_i = seq; trig_addr_i = addr; trig_len_i = len;
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  task automatic wait_end(int d0, int e0);
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (done_cnt > d0 || err_cnt > e0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "idle_o", idle_o, 1);
    chk("R1", "cs_no", cs_no, 1);
    chk("R1", "sck_o", sck_o, 0);
    chk("R1", "done/err", {done_o, err_o}, 0);
  endtask

  task automatic t_table();
    write_word(6'd63, 32'hDEAD_BEEF);
    tbl_addr_i = 6'd63;
    #1;
    chk("R2", "table readback", tbl_rdata_o, 32'hDEAD_BEEF);
  endtask

  task automatic t_cmd_single();
    int n0 = nb, d0 = done_cnt, e0 = err_cnt;
    logic [7:0] v = 8'h00;
    int oe_bad = 0;
    load(4'd1, {16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, mk(6'h00, 2'd0, 8'h00), mk(6'h01, 2'd0, 8'h9F)});
    fire(4'd1, 32'h0, 12'd0);
    wait_end(d0, e0);
    chk("R3", "beats", nb - n0, 8);
    for (int i = 0; i < 8; i++) begin
      v = {v[6:0], beat_dq[(n0 + i) % 512][0]};
      if (beat_oe[(n0 + i) % 512] != 8'h01) oe_bad++;
    end
    chk("R3", "opcode bits", v, 8'h9F);
    chk("R4", "1-line oe mismatches", oe_bad, 0);
    chk("R9", "done pulses", done_cnt - d0, 1);
    chk("R9", "cs_no after stop", cs_no, 1);
    chk("R9", "idle after stop", idle_o, 1);
  endtask

  task automatic t_addr_quad();
    int n0 = nb, d0 = done_cnt, e0 = err_cnt;
    logic [31:0] v = 32'h0;
    int oe_bad = 0;
    load(4'd3, {16'h0, 16'h0, 16'h0, 16'h0, 16'h0, mk(6'h00, 2'd0, 8'h00),
                mk(6'h02, 2'd2, 8'd24), mk(6'h01, 2'd2, 8'hEB)});
    fire(4'd3, 32'hAB12_3456, 12'd0);
    wait_end(d0, e0);
    chk("R5", "beats", nb - n0, 8);
    for (int i = 0; i < 8; i++) begin
      v = {v[27:0], beat_dq[(n0 + i) % 512][3:0]};
      if (beat_oe[(n0 + i) % 512] != 8'h0F) oe_bad++;
    end
    chk("R5", "cmd+addr nibbles", v, 32'hEB12_3456);
    chk("R4", "4-line oe mismatches", oe_bad, 0);
    chk("R2", "odd instruction done", done_cnt - d0, 1);
  endtask

  task automatic t_write_octal();
    int n0 = nb, d0 = done_cnt, e0 = err_cnt;
    load(4'd4, {16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, mk(6'h00, 2'd0, 8'h00), mk(6'h08, 2'd3, 8'h00)});
    tx_block = 1'b1;
    tx_mem[tx_wr % 16] = 8'hA5; tx_mem[(tx_wr + 1) % 16] = 8'h3C; tx_mem[(tx_wr + 2) % 16] = 8'h7E;
    tx_wr = tx_wr + 3;
    fire(4'd4, 32'h0, 12'd3);
    repeat (20) @(negedge clk);
    chk("R7", "beats during tx stall", nb - n0, 0);
    chk("R7", "sck during stall", sck_o, 0);
    chk("R7", "cs held during stall", cs_no, 0);
    fire(4'd1, 32'h0, 12'd0);
    chk("R11", "busy after ignored trigger", idle_o, 0);
    tx_block = 1'b0;
    wait_end(d0, e0);
    chk("R7", "beats", nb - n0, 3);
    chk("R7", "byte0", beat_dq[n0 % 512], 8'hA5);
    chk("R7", "byte1", beat_dq[(n0 + 1) % 512], 8'h3C);
    chk("R7", "byte2", beat_dq[(n0 + 2) % 512], 8'h7E);
    chk("R4", "8-line oe", beat_oe[n0 % 512], 8'hFF);
    chk("R7", "tx fifo drained", tx_wr - tx_rd, 0);
    repeat (20) @(negedge clk);
    chk("R11", "no extra beats", nb - n0, 3);
    chk("R11", "single done", done_cnt - d0, 1);
  endtask

  task automatic t_read_dual();
    int n0 = nb, d0 = done_cnt, e0 = err_cnt, r0 = rx_n;
    logic [7:0] oe_or = 8'h00;
    load(4'd5, {16'h0, 16'h0, 16'h0, 16'h0, mk(6'h00, 2'd0, 8'h00), mk(6'h09, 2'd1, 8'h00),
                mk(6'h0C, 2'd0, 8'd4), mk(6'h01, 2'd0, 8'h3B)});
    rd_bytes[0] = 8'hC6; rd_bytes[1] = 8'h19;
    rd_n = 2; rd_skip = 4; rd_z0 = z_cnt; rd_en = 1'b1;
    rx_block = 1'b1;
    fire(4'd5, 32'h0, 12'd2);
    for (int c = 0; c < 500; c++) begin
      @(negedge clk);
      if (nb - n0 >= 16) break;
    end
    repeat (10) @(negedge clk);
    chk("R8", "beats while rx full", nb - n0, 16);
    chk("R8", "no push while full", rx_n - r0, 0);
    rx_block = 1'b0;
    wait_end(d0, e0);
    rd_en = 1'b0;
    chk("R8", "total beats", nb - n0, 20);
    chk("R8", "pushes", rx_n - r0, 2);
    chk("R8", "rx byte0", rx_got[r0 % 16], 8'hC6);
    chk("R8", "rx byte1", rx_got[(r0 + 1) % 16], 8'h19);
    for (int i = 8; i < 12; i++) oe_or |= beat_oe[(n0 + i) % 512];
    chk("R6", "dummy oe", oe_or, 8'h00);
    chk("R9", "done after read", done_cnt - d0, 1);
  endtask

  task automatic t_abort(logic [3:0] seq, logic [7:0][15:0] p, int exp_beats, string what);
    int n0 = nb, d0 = done_cnt, e0 = err_cnt;
    load(seq, p);
    fire(seq, 32'h0, 12'd0);
    wait_end(d0, e0);
    chk("R10", {what, " err"}, err_cnt - e0, 1);
    chk("R10", {what, " no done"}, done_cnt - d0, 0);
    chk("R10", {what, " beats"}, nb - n0, exp_beats);
    chk("R10", {what, " cs_no"}, cs_no, 1);
    chk("R10", {what, " idle"}, idle_o, 1);
  endtask

  task automatic t_len_zero();
    int n0 = nb, d0 = done_cnt, e0 = err_cnt, t0 = tx_rd;
    load(4'd10, {16'h0, 16'h0, 16'h0, 16'h0, 16'h0, mk(6'h00, 2'd0, 8'h00),
                 mk(6'h08, 2'd0, 8'h00), mk(6'h01, 2'd0, 8'h06)});
    fire(4'd10, 32'h0, 12'd0);
    wait_end(d0, e0);
    chk("R7", "zero-length beats", nb - n0, 8);
    chk("R7", "zero-length pops", tx_rd - t0, 0);
    chk("R7", "zero-length done", done_cnt - d0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_table();
    t_cmd_single();
    t_addr_quad();
    t_write_octal();
    t_read_dual();
    t_abort(4'd6, {16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, mk(6'h05, 2'd0, 8'h00)}, 0, "bad opcode");
    t_abort(4'd7, {8{mk(6'h0C, 2'd0, 8'd1)}}, 8, "no stop");
    t_abort(4'd8, {16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, mk(6'h00, 2'd0, 8'h00), mk(6'h02, 2'd0, 8'd33)}, 0, "addr range");
    t_abort(4'd9, {16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, mk(6'h00, 2'd0, 8'h00), mk(6'h0C, 2'd0, 8'd65)}, 0, "dummy range");
    t_len_zero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule